// File: doc/BRIEF.md
# Single-Wire Reset and Presence Responder

This block is the timing front end of a slave on a single-wire, open-drain bus. The line idles high through an external pull-up. The master starts every signalling event on the line. The slave's only spontaneous act is to answer a reset. The block oversamples the line with the system clock and resynchronises it through a two-stage flop chain. It then measures how many consecutive cycles the line stays low. When the line rises after a low period that was long enough, it tells the upper layer with a one-cycle pulse.

After that pulse the block waits a fixed delay. It then enables its pull-down for a fixed width; this low period is the presence pulse that the master listens for. With a 50 MHz clock the default durations are:

| Duration | Cycles | Time | Allowed window |
|---|---|---|---|
| Reset threshold | 24000 | 480 us | at least 480 us |
| Presence delay | 1500 | 30 us | 15 to 60 us |
| Presence width | 6000 | 120 us | 60 to 240 us |

The delay and width sit in the middle of their windows. All three are parameters counted in clock cycles.

The block watches the line as it really is, so its own pull-down also counts as low time. For that reason the presence width must be shorter than the reset threshold. The bit slots and command decoding belong to the layer above. That layer consumes `reset_seen_o` and combines its own data pull-down with `pull_low_o`. No data stream passes through this block, so it has no handshake: every pin is a plain level or a single-cycle strobe.

Top module: `swr_reset_responder`

## Requirements
- R1: While `rst_ni` is low, and in the first cycle after it, `pull_low_o` and `reset_seen_o` are 0. The resynchronised line is taken as high (idle).
- R2: A low that lasts RST_LOW_CYC or more cycles, followed by a rise of `line_i`, gives exactly one single-cycle pulse on `reset_seen_o`. The pulse is high in the third cycle after the cycle in which `line_i` went high: two synchroniser stages plus one output register.
- R3: A low of RST_LOW_CYC-1 cycles or fewer produces no `reset_seen_o` pulse and no presence pulse.
- R4: `pull_low_o` goes high exactly WAIT_CYC cycles after the cycle in which `reset_seen_o` was high.
- R5: Once high, `pull_low_o` stays high for exactly PRES_CYC consecutive cycles and then returns to 0.
- R6: `pull_low_o` is never asserted unless a `reset_seen_o` pulse has come before it.
- R7: If the resynchronised line falls while the block is still waiting to send the presence pulse, the wait is abandoned and no presence pulse is driven.
- R8: A master low that starts while the presence pulse is being driven, and ends with the line low for RST_LOW_CYC cycles or more in total, counts as a new reset. Its rise produces a fresh `reset_seen_o` pulse and a complete new delay and presence sequence.
- R9: The line rising at the end of the block's own presence pulse is never taken as a reset (PRES_CYC must be below RST_LOW_CYC).
- R10: A low far longer than RST_LOW_CYC, for example three times it, still gives exactly one `reset_seen_o` pulse, with the same R2 and R4 timing. The low-time counter saturates instead of wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oversampling system clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| line_i | input | 1 | Bus line as seen at the pad, asynchronous to `clk_i` |
| pull_low_o | output | 1 | Pull-down enable for the open-drain pad; high means pull the line low |
| reset_seen_o | output | 1 | One-cycle strobe to the upper layer when a valid reset has ended |

## Verification
Each result is due a fixed number of cycles after its stimulus:
- The reset strobe lands three cycles after `line_i` is released.
- `pull_low_o` rises WAIT_CYC cycles after the strobe and holds for PRES_CYC cycles.
- A cancelled wait or a too-short low shows no activity at all in the window where a presence pulse would have appeared.

The bench changes `line_i` and samples the outputs only on falling clock edges. It numbers those edges from the release of the line, so every expected edge index follows directly from these counts. The bench also models the wired-AND line, so the block's own pull-down is fed back into it, as it would be on a real bus.

// File: rtl/swr_pkg.sv
package swr_pkg;

  // Sequencer phases after a reset ends.
  typedef enum logic [1:0] {
    SWR_IDLE  = 2'd0,
    SWR_DELAY = 2'd1,
    SWR_DRIVE = 2'd2
  } swr_phase_e;

  function automatic int unsigned swr_max(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/swr_sync.sv
// Multi-stage resynchroniser for an asynchronous input; resets to IDLE_VAL.
module swr_sync #(
  parameter int unsigned STAGES   = 2,
  parameter logic        IDLE_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic sync_o
);

  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q <= IDLE_VAL;
        else         chain_q <= async_i;
      end
    end else begin : g_multi
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q <= {STAGES{IDLE_VAL}};
        else         chain_q <= {chain_q[STAGES-2:0], async_i};
      end
    end
  endgenerate

  assign sync_o = chain_q[STAGES-1];

endmodule

// File: rtl/swr_low_timer.sv
// Measures consecutive low cycles of the resynchronised line and flags edges.
module swr_low_timer #(
  parameter int unsigned LIMIT = 24000,
  localparam int unsigned CW   = $clog2(LIMIT + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_s_i,
  output logic long_low_o,
  output logic rise_o,
  output logic fall_o
);

  logic          line_q;
  logic [CW-1:0] low_cnt_q;
  logic          at_limit;

  assign at_limit = (low_cnt_q == CW'(LIMIT));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      line_q    <= 1'b1;
      low_cnt_q <= '0;
    end else begin
      line_q <= line_s_i;
      if (line_s_i)
        low_cnt_q <= '0;
      else if (!at_limit)
        low_cnt_q <= low_cnt_q + CW'(1);
    end
  end

  // The count still holds the finished low period in the first high cycle.
  assign long_low_o = at_limit;
  assign rise_o     = line_s_i & ~line_q;
  assign fall_o     = ~line_s_i & line_q;

endmodule

// File: rtl/swr_presence_seq.sv
// Delay-then-drive sequencer started by the end of a valid reset.
module swr_presence_seq
  import swr_pkg::*;
#(
  parameter int unsigned WAIT_CYC = 1500,
  parameter int unsigned PRES_CYC = 6000,
  localparam int unsigned TW      = $clog2(swr_max(WAIT_CYC, PRES_CYC) + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rise_i,
  input  logic fall_i,
  input  logic long_low_i,
  output logic reset_seen_o,
  output logic pull_o
);

  swr_phase_e    phase_q, phase_d;
  logic [TW-1:0] tmr_q, tmr_d;
  logic          seen_d;
  logic          reset_end;

  assign reset_end = rise_i & long_low_i;

  always_comb begin
    phase_d = phase_q;
    tmr_d   = tmr_q;
    seen_d  = 1'b0;
    if (reset_end) begin
      // A finished reset restarts the sequence from any phase.
      seen_d  = 1'b1;
      phase_d = SWR_DELAY;
      tmr_d   = TW'(WAIT_CYC - 1);
    end else begin
      unique case (phase_q)
        SWR_IDLE: ;
        SWR_DELAY: begin
          if (fall_i) begin
            phase_d = SWR_IDLE;
            tmr_d   = '0;
          end else if (tmr_q == '0) begin
            phase_d = SWR_DRIVE;
            tmr_d   = TW'(PRES_CYC - 1);
          end else begin
            tmr_d = tmr_q - TW'(1);
          end
        end
        SWR_DRIVE: begin
          if (tmr_q == '0) phase_d = SWR_IDLE;
          else             tmr_d   = tmr_q - TW'(1);
        end
        default: begin
          phase_d = SWR_IDLE;
          tmr_d   = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q      <= SWR_IDLE;
      tmr_q        <= '0;
      reset_seen_o <= 1'b0;
    end else begin
      phase_q      <= phase_d;
      tmr_q        <= tmr_d;
      reset_seen_o <= seen_d;
    end
  end

  assign pull_o = (phase_q == SWR_DRIVE);

endmodule

// File: rtl/swr_reset_responder.sv
// Top: resynchroniser, low-time measurement and presence sequencer.
module swr_reset_responder #(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned RST_LOW_CYC = 24000,
  parameter int unsigned WAIT_CYC    = 1500,
  parameter int unsigned PRES_CYC    = 6000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_i,
  output logic pull_low_o,
  output logic reset_seen_o
);

  logic line_sync;
  logic long_low;
  logic line_rise;
  logic line_fall;

  swr_sync #(
    .STAGES  (SYNC_STAGES),
    .IDLE_VAL(1'b1)
  ) i_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .async_i(line_i),
    .sync_o (line_sync)
  );

  swr_low_timer #(
    .LIMIT(RST_LOW_CYC)
  ) i_low_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .line_s_i  (line_sync),
    .long_low_o(long_low),
    .rise_o    (line_rise),
    .fall_o    (line_fall)
  );

  swr_presence_seq #(
    .WAIT_CYC(WAIT_CYC),
    .PRES_CYC(PRES_CYC)
  ) i_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rise_i      (line_rise),
    .fall_i      (line_fall),
    .long_low_i  (long_low),
    .reset_seen_o(reset_seen_o),
    .pull_o      (pull_low_o)
  );

endmodule

// File: rtl/swr_reset_responder_chk.sv
module swr_reset_responder_chk #(
  parameter int unsigned RST_LOW_CYC = 24000,
  parameter int unsigned WAIT_CYC    = 1500,
  parameter int unsigned PRES_CYC    = 6000
) (
  input logic clk_i,
  input logic rst_ni,
  input logic line_sync,
  input logic pull_low_o,
  input logic reset_seen_o
);

  int unsigned low_run;
  int unsigned pull_run;
  int unsigned since_seen;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      low_run    <= 0;
      pull_run   <= 0;
      since_seen <= 0;
    end else begin
      if (line_sync)                  low_run <= 0;
      else if (low_run < RST_LOW_CYC) low_run <= low_run + 1;
      pull_run <= pull_low_o ? pull_run + 1 : 0;
      if (reset_seen_o)                             since_seen <= 1;
      else if (since_seen != 0 && since_seen <= WAIT_CYC) since_seen <= since_seen + 1;
    end
  end

  // R2
  seen_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reset_seen_o |=> !reset_seen_o);

  // R2
  seen_after_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(reset_seen_o) |-> ($past(line_sync) && !$past(line_sync, 2)));

  // R3
  seen_needs_long_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(reset_seen_o) |-> ($past(low_run) >= RST_LOW_CYC));

  // R4
  pull_delay_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pull_low_o) |-> (since_seen == WAIT_CYC));

  // R5
  pull_max_width_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pull_low_o |-> (pull_run < PRES_CYC));

  // R5
  pull_full_width_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(pull_low_o) |-> (pull_run == PRES_CYC));

endmodule

bind swr_reset_responder swr_reset_responder_chk #(
  .RST_LOW_CYC(RST_LOW_CYC),
  .WAIT_CYC   (WAIT_CYC),
  .PRES_CYC   (PRES_CYC)
) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .line_sync   (line_sync),
  .pull_low_o  (pull_low_o),
  .reset_seen_o(reset_seen_o)
);

// File: tb/test_swr_reset_responder.sv
`timescale 1ns/1ps
module test_swr_reset_responder;

  localparam int RST  = 40;
  localparam int DLY  = 8;
  localparam int PRS  = 20;
  localparam int SPAN = 3 + DLY + PRS + 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic master_low = 1'b0;
  logic pull_low;
  logic reset_seen;
  wire  line = ~(master_low | pull_low);

  int n_vec = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  swr_reset_responder #(
    .SYNC_STAGES(2),
    .RST_LOW_CYC(RST),
    .WAIT_CYC   (DLY),
    .PRES_CYC   (PRS)
  ) i_swr_reset_responder (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .line_i      (line),
    .pull_low_o  (pull_low),
    .reset_seen_o(reset_seen)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_vec++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Edge 0 is the caller's current falling edge; samples edges 1..span.
  task automatic observe(input int span, output int seen_at, output int seen_cnt,
                         output int pull_at, output int pull_len);
    seen_at = -1; seen_cnt = 0; pull_at = -1; pull_len = 0;
    for (int i = 1; i <= span; i++) begin
      @(negedge clk);
      if (reset_seen) begin seen_cnt++; if (seen_at < 0) seen_at = i; end
      if (pull_low)   begin pull_len++; if (pull_at < 0) pull_at = i; end
    end
  endtask

  // Hold the line low for n cycles; returns at the releasing falling edge.
  task automatic hold_low(input int n);
    @(negedge clk);
    master_low = 1'b1;
    repeat (n) @(negedge clk);
    master_low = 1'b0;
  endtask

  task automatic t_reset_state();
    chk("R1 pull_low in reset", int'(pull_low), 0);
    chk("R1 reset_seen in reset", int'(reset_seen), 0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk("R1 pull_low after reset", int'(pull_low), 0);
    chk("R1 reset_seen after reset", int'(reset_seen), 0);
  endtask

  task automatic t_exact_threshold();
    int sa, sc, pa, pl;
    hold_low(RST);
    observe(SPAN, sa, sc, pa, pl);
    chk("R2 strobe edge", sa, 3);
    chk("R2 R9 strobe count", sc, 1);
    chk("R4 presence start", pa, 3 + DLY);
    chk("R5 presence width", pl, PRS);
  endtask

  task automatic t_short_low();
    int sa, sc, pa, pl;
    hold_low(RST - 1);
    observe(SPAN, sa, sc, pa, pl);
    chk("R3 no strobe", sc, 0);
    chk("R3 no presence", pl, 0);
  endtask

  task automatic t_very_long_low();
    int sa, sc, pa, pl;
    hold_low(3 * RST);
    observe(SPAN, sa, sc, pa, pl);
    chk("R10 strobe count", sc, 1);
    chk("R10 strobe edge", sa, 3);
    chk("R10 presence start", pa, 3 + DLY);
    chk("R10 presence width", pl, PRS);
  endtask

  task automatic t_cancel_wait();
    int sa, sc, pa, pl, sa2, sc2, pa2, pl2;
    hold_low(RST);
    observe(5, sa, sc, pa, pl);
    master_low = 1'b1;
    observe(3, sa2, sc2, pa2, pl2);
    master_low = 1'b0;
    pl = pl + pl2;
    observe(SPAN, sa2, sc2, pa2, pl2);
    chk("R7 strobe before cancel", sc, 1);
    chk("R7 no presence after cancel", pl + pl2, 0);
    chk("R7 no strobe from short low", sc2, 0);
  endtask

  task automatic t_restart_in_presence();
    int sa, sc, pa, pl;
    hold_low(RST);
    observe(3 + DLY, sa, sc, pa, pl);
    chk("R8 first presence started", pa, 3 + DLY);
    observe(5, sa, sc, pa, pl);
    master_low = 1'b1;
    observe(RST, sa, sc, pa, pl);
    chk("R9 no strobe while held", sc, 0);
    master_low = 1'b0;
    observe(SPAN, sa, sc, pa, pl);
    chk("R8 restart strobe edge", sa, 3);
    chk("R8 restart strobe count", sc, 1);
    chk("R8 restart presence start", pa, 3 + DLY);
    chk("R8 restart presence width", pl, PRS);
  endtask

  task automatic t_idle_quiet();
    int sa, sc, pa, pl;
    observe(60, sa, sc, pa, pl);
    chk("R6 no presence when idle", pl, 0);
    chk("R6 no strobe when idle", sc, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset_state();
    t_idle_quiet();
    t_exact_threshold();
    t_short_low();
    t_very_long_low();
    t_cancel_wait();
    t_restart_in_presence();
    t_idle_quiet();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

endmodule